// File: doc/BRIEF.md
# I2C Bus Master Controller

This block is a master-only I2C controller. A host issues one command at a time: generate a start condition, send one byte, receive one byte, or generate a stop condition. The controller then runs the matching bus sequence on open-drain SCL and SDA pins. It never responds as a slave. A typical use is reading boot bytes from a serial EEPROM: start, address write, repeated start, a run of reads with the last one NACKed, and a stop.

The bus rate is set by a two-bit selector that programs a quarter-bit prescaler. A lock input forces the slowest rate, for supplies that cannot run faster. A slave may hold SCL low to slow the transfer. The controller waits for SCL to read high before it times the high phase. A bus monitor tracks start and stop conditions from every master on the bus. The controller will not start while another master holds the bus. It steps off the bus when it loses arbitration.

Top module: `i2c_mstr`

## Requirements
- R1: After reset both line enables `scl_oe_o` and `sda_oe_o` are 0 (released), `cmd_ready_o` is 1 and `bus_busy_o` is 0. An enable of 1 pulls its line low. A line is never driven high.
- R2: `rate_sel_i` encodes 0 = 100 kHz, 1 = 400 kHz, 2 = 1 MHz, 3 = 100 kHz. One quarter-bit lasts CLK_HZ/(4*rate) cycles, truncated. The SCL period within a byte is four quarters plus the synchronizer delay (at most 6 extra cycles).
- R3: While `slow_lock_i` is 1, the 100 kHz timing is used whatever `rate_sel_i` says.
- R4: `cmd_i` encodes 0 = START, 1 = STOP, 2 = WRITE, 3 = READ. WRITE sends `wdata_i` MSB first. SDA is stable while SCL is high.
- R5: On the ninth clock of a WRITE, the master releases SDA and samples it. When `done_o` pulses, `ack_err_o` is 1 if SDA was high (NACK) and 0 if it was low.
- R6: READ samples eight bits MSB first into `rdata_o`, which is valid when `done_o` pulses. On the ninth clock the master pulls SDA low if `rd_nack_i` was 0 and releases it if `rd_nack_i` was 1.
- R7: After the master releases SCL, it waits until SCL reads high before timing the high phase. A stretched bit therefore keeps a high time of two quarters plus the synchronizer delay.
- R8: `bus_busy_o` rises after any start condition seen on the pins (SDA falls while SCL is high). It falls after any stop condition (SDA rises while SCL is high).
- R9: A START while `bus_busy_o` is 1 and the controller does not own the bus is refused. `cmd_err_o` pulses and neither line is touched.
- R10: WRITE, READ or STOP issued while the controller does not own the bus is refused with a `cmd_err_o` pulse.
- R11: If SDA reads low during bits 1 to 8 of a WRITE while the master is releasing it, `arb_lost_o` pulses. Both lines are released, the controller goes idle without a stop, and the bus stays busy.
- R12: A START while the controller owns the bus produces a repeated start.
- R13: On the pins, a transfer shows one start per START command and one stop per STOP command. Data and ACK bits never create a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 2 | Bus rate select |
| slow_lock_i | input | 1 | Force 100 kHz timing |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | Command code |
| wdata_i | input | 8 | Byte to send on WRITE |
| rd_nack_i | input | 1 | READ: 1 = NACK on ninth clock |
| cmd_ready_o | output | 1 | Idle, able to take a command |
| done_o | output | 1 | One-cycle pulse when a command completes |
| rdata_o | output | 8 | Last byte received |
| ack_err_o | output | 1 | Last WRITE was NACKed |
| cmd_err_o | output | 1 | One-cycle pulse when a command is refused |
| arb_lost_o | output | 1 | One-cycle pulse on arbitration loss |
| bus_busy_o | output | 1 | Bus held by some master |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The bench holds SCL low for hundreds of cycles in the middle of a byte. It then measures the next high pulse. A design that counted through the stretch would shorten that pulse or lose a bit. It forces SDA low under a released 1 bit and checks that the bus stays busy. A design that sent a stop after losing arbitration would clear busy. It also checks that the master stays silent when another master's start is already on the pins. Pin-level start and stop counters catch a design that moves SDA while SCL is high during data or ACK bits. Period measurements at each rate and under the lock catch a wrong prescaler value.

// File: rtl/i2c_mstr_pkg.sv
package i2c_mstr_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_STOP
  } st_e;

  typedef enum logic [1:0] {
    RATE_STD   = 2'd0,
    RATE_FAST  = 2'd1,
    RATE_FPLUS = 2'd2,
    RATE_RSVD  = 2'd3
  } rate_e;
endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer
  import i2c_mstr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_sel_i,
  input  logic       slow_lock_i,
  input  logic       run_i,
  output logic       tick_o
);
  localparam int unsigned QStd = CLK_HZ / 400_000;
  localparam int unsigned QFast = CLK_HZ / 1_600_000;
  localparam int unsigned QFplus = CLK_HZ / 4_000_000;
  localparam int unsigned CW = $clog2(QStd + 1);

  logic [CW-1:0] lim, cnt_q;

  always_comb begin
    if (slow_lock_i) lim = CW'(QStd);
    else begin
      case (rate_e'(rate_sel_i))
        RATE_FAST:  lim = CW'(QFast);
        RATE_FPLUS: lim = CW'(QFplus);
        default:    lim = CW'(QStd);
      endcase
    end
  end

  // >= keeps a mid-count rate change from running past the new limit
  assign tick_o = run_i && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(QStd));
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic busy_o
);
  logic [1:0] scl_sync_q, sda_sync_q;
  logic       sda_prev_q, busy_q;
  logic       start_det, stop_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
      sda_prev_q <= sda_sync_q[1];
    end
  end

  assign start_det = scl_sync_q[1] && sda_prev_q && !sda_sync_q[1];
  assign stop_det  = scl_sync_q[1] && !sda_prev_q && sda_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else if (start_det) busy_q <= 1'b1;
    else if (stop_det) busy_q <= 1'b0;
  end

  assign scl_s_o = scl_sync_q[1];
  assign sda_s_o = sda_sync_q[1];
  assign busy_o  = busy_q;

  // R8
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> busy_o);
  // R8
  busy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_o);
endmodule

// File: rtl/i2c_mstr.sv
module i2c_mstr
  import i2c_mstr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_sel_i,
  input  logic       slow_lock_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_nack_i,
  output logic       cmd_ready_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       ack_err_o,
  output logic       cmd_err_o,
  output logic       arb_lost_o,
  output logic       bus_busy_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam logic [3:0] AckIdx = 4'd8;

  st_e        st_q;
  logic [1:0] ph_q;
  logic [3:0] idx_q;
  logic [7:0] sh_q, rdata_q;
  logic       rd_q, nack_q, owner_q, ack_bit_q;
  logic       scl_oe_q, sda_oe_q;
  logic       done_q, ack_err_q, cmd_err_q, arb_q;
  logic       scl_s, sda_s, busy, tick, wait_scl, run;

  i2c_bus_mon u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .scl_s_o(scl_s),
    .sda_s_o(sda_s),
    .busy_o (busy)
  );

  // phase 2 of every sequence follows an SCL release: hold until the line reads high
  assign wait_scl = (ph_q == 2'd2) && !scl_s;
  assign run      = (st_q != ST_IDLE) && !wait_scl;

  i2c_qtr_timer #(.CLK_HZ(CLK_HZ)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sel_i (rate_sel_i),
    .slow_lock_i(slow_lock_i),
    .run_i      (run),
    .tick_o     (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= 2'd0;
      idx_q     <= 4'd0;
      sh_q      <= 8'h00;
      rdata_q   <= 8'h00;
      rd_q      <= 1'b0;
      nack_q    <= 1'b0;
      owner_q   <= 1'b0;
      ack_bit_q <= 1'b0;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      done_q    <= 1'b0;
      ack_err_q <= 1'b0;
      cmd_err_q <= 1'b0;
      arb_q     <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      cmd_err_q <= 1'b0;
      arb_q     <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          ph_q <= 2'd0;
          if (cmd_valid_i) begin
            case (cmd_e'(cmd_i))
              CMD_START: begin
                if (busy && !owner_q) cmd_err_q <= 1'b1;
                else st_q <= ST_START;
              end
              CMD_STOP: begin
                if (!owner_q) cmd_err_q <= 1'b1;
                else st_q <= ST_STOP;
              end
              default: begin
                if (!owner_q) cmd_err_q <= 1'b1;
                else begin
                  st_q   <= ST_BIT;
                  idx_q  <= 4'd0;
                  rd_q   <= (cmd_i == CMD_READ);
                  sh_q   <= (cmd_i == CMD_READ) ? 8'h00 : wdata_i;
                  nack_q <= rd_nack_i;
                end
              end
            endcase
          end
        end
        ST_START: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_oe_q <= 1'b0;
            2'd1: scl_oe_q <= 1'b0;
            2'd2: sda_oe_q <= 1'b1;
            default: begin
              scl_oe_q <= 1'b1;
              owner_q  <= 1'b1;
              done_q   <= 1'b1;
              st_q     <= ST_IDLE;
            end
          endcase
        end
        ST_STOP: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_oe_q <= 1'b1;
            2'd1: scl_oe_q <= 1'b0;
            2'd2: sda_oe_q <= 1'b0;
            default: begin
              owner_q <= 1'b0;
              done_q  <= 1'b1;
              st_q    <= ST_IDLE;
            end
          endcase
        end
        default: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: begin
              if (idx_q == AckIdx) sda_oe_q <= rd_q ? !nack_q : 1'b0;
              else sda_oe_q <= rd_q ? 1'b0 : !sh_q[7];
            end
            2'd1: scl_oe_q <= 1'b0;
            2'd2: begin
              if (idx_q != AckIdx && !rd_q && !sda_oe_q && !sda_s) begin
                // another master pulled a released 1 bit low
                scl_oe_q <= 1'b0;
                sda_oe_q <= 1'b0;
                owner_q  <= 1'b0;
                arb_q    <= 1'b1;
                st_q     <= ST_IDLE;
              end else if (idx_q != AckIdx) sh_q <= {sh_q[6:0], sda_s};
              else ack_bit_q <= sda_s;
            end
            default: begin
              scl_oe_q <= 1'b1;
              if (idx_q == AckIdx) begin
                done_q    <= 1'b1;
                ack_err_q <= !rd_q && ack_bit_q;
                if (rd_q) rdata_q <= sh_q;
                st_q      <= ST_IDLE;
              end else idx_q <= idx_q + 4'd1;
            end
          endcase
        end
      endcase
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign ack_err_o   = ack_err_q;
  assign cmd_err_o   = cmd_err_q;
  assign arb_lost_o  = arb_q;
  assign bus_busy_o  = busy;
  assign scl_oe_o    = scl_oe_q;
  assign sda_oe_o    = sda_oe_q;

  // R11
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> (!scl_oe_o && !sda_oe_o && cmd_ready_o));
  // R9
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_i == CMD_START && bus_busy_o && !owner_q)
      |=> (cmd_err_o && cmd_ready_o));
  // R10
  no_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_i != CMD_START && !owner_q) |=> cmd_err_o);
  // R13
  sda_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT && !$stable(sda_oe_q)) |-> scl_oe_q);
  // R7
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && wait_scl) |=> ($stable(ph_q) && $stable(st_q)));
  // R10
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, cmd_err_o, arb_lost_o}));
endmodule

// File: tb/i2c_mstr_tb_top.sv
module i2c_mstr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd2;
  logic       slow_lock = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       rd_nack = 1'b0;
  logic       cmd_ready, done, ack_err, cmd_err, arb_lost, bus_busy;
  logic [7:0] rdata;
  logic       scl_oe, sda_oe;
  logic       ext_scl_lo = 1'b0, ext_sda_lo = 1'b0;
  logic       scl, sda;

  assign scl = !(scl_oe || ext_scl_lo);
  assign sda = !(sda_oe || ext_sda_lo);

  always #5 clk = ~clk;

  i2c_mstr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(rate_sel), .slow_lock_i(slow_lock),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .wdata_i(wdata), .rd_nack_i(rd_nack),
    .cmd_ready_o(cmd_ready), .done_o(done), .rdata_o(rdata), .ack_err_o(ack_err),
    .cmd_err_o(cmd_err), .arb_lost_o(arb_lost), .bus_busy_o(bus_busy),
    .scl_i(scl), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_start = 0, n_stop = 0;
  logic r_done, r_err, r_arb, r_ackerr;
  logic [7:0] r_rdata, s_got;
  logic s_mack;
  int s_hiw, p_period;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge sda) if (scl === 1'b1) n_start++;
  always @(posedge sda) if (scl === 1'b1) n_stop++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic host_cmd(input logic [1:0] c, input logic [7:0] d, input logic n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wdata = d; rd_nack = n;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!(done || cmd_err || arb_lost)) @(negedge clk);
    r_done = done; r_err = cmd_err; r_arb = arb_lost;
    r_ackerr = ack_err; r_rdata = rdata;
  endtask

  task automatic slv_write(input logic ack, input int stretch);
    int t0;
    s_hiw = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl);
      t0 = cyc;
      s_got = {s_got[6:0], sda};
      @(negedge scl);
      if (i == 4) s_hiw = cyc - t0;
      if (i == 3 && stretch > 0) begin
        ext_scl_lo = 1'b1;
        repeat (stretch) @(posedge clk);
        ext_scl_lo = 1'b0;
      end
    end
    ext_sda_lo = ack;
    @(posedge scl);
    @(negedge scl);
    ext_sda_lo = 1'b0;
  endtask

  task automatic slv_read(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      ext_sda_lo = !v[7-i];
      @(posedge scl);
      @(negedge scl);
    end
    ext_sda_lo = 1'b0;
    @(posedge scl);
    s_mack = !sda;
    @(negedge scl);
  endtask

  task automatic meas_period();
    int t0;
    @(posedge scl);
    t0 = cyc;
    @(posedge scl);
    p_period = cyc - t0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 busy", bus_busy, 0);
  endtask

  task automatic t_no_owner();
    host_cmd(2'd2, 8'h55, 1'b0);
    chk("R10 write refused", r_err, 1);
    host_cmd(2'd1, 8'h00, 1'b0);
    chk("R10 stop refused", r_err, 1);
    chk("R10 lines idle", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_main();
    n_start = 0; n_stop = 0;
    rate_sel = 2'd2;
    host_cmd(2'd0, 8'h00, 1'b0);
    chk("R8 busy after start", bus_busy, 1);
    fork host_cmd(2'd2, 8'hA6, 1'b0); slv_write(1'b1, 0); join
    chk("R4 byte msb first", s_got, 8'hA6);
    chk("R5 ack ok", r_ackerr, 0);
    fork host_cmd(2'd2, 8'h3C, 1'b0); slv_write(1'b0, 0); join
    chk("R5 nack flagged", r_ackerr, 1);
    host_cmd(2'd0, 8'h00, 1'b0);
    chk("R12 repeated start done", {r_done, r_err}, 2);
    fork host_cmd(2'd3, 8'h00, 1'b0); slv_read(8'h5A); join
    chk("R6 rdata", r_rdata, 8'h5A);
    chk("R6 master ack", s_mack, 1);
    fork host_cmd(2'd3, 8'h00, 1'b1); slv_read(8'hC3); join
    chk("R6 rdata last", r_rdata, 8'hC3);
    chk("R6 master nack", s_mack, 0);
    host_cmd(2'd1, 8'h00, 1'b0);
    chk("R8 busy after stop", bus_busy, 0);
    chk("R13 starts", n_start, 2);
    chk("R13 stops", n_stop, 1);
    chk("R1 released after stop", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_rate(input logic [1:0] sel, input logic lock, input int q, input string req);
    rate_sel = sel; slow_lock = lock;
    host_cmd(2'd0, 8'h00, 1'b0);
    fork host_cmd(2'd2, 8'h96, 1'b0); slv_write(1'b1, 0); meas_period(); join
    chk_rng(req, p_period, 4 * q, 4 * q + 6);
    host_cmd(2'd1, 8'h00, 1'b0);
    slow_lock = 1'b0;
  endtask

  task automatic t_stretch();
    rate_sel = 2'd2;
    host_cmd(2'd0, 8'h00, 1'b0);
    fork host_cmd(2'd2, 8'hE1, 1'b0); slv_write(1'b1, 400); join
    chk("R7 data through stretch", s_got, 8'hE1);
    chk_rng("R7 high after stretch", s_hiw, 50, 56);
    host_cmd(2'd1, 8'h00, 1'b0);
  endtask

  task automatic t_busy_refuse();
    ext_sda_lo = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 foreign start seen", bus_busy, 1);
    host_cmd(2'd0, 8'h00, 1'b0);
    chk("R9 start refused", r_err, 1);
    repeat (30) @(negedge clk);
    chk("R9 lines untouched", {scl_oe, sda_oe}, 0);
    ext_sda_lo = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 foreign stop seen", bus_busy, 0);
  endtask

  task automatic t_arb();
    host_cmd(2'd0, 8'h00, 1'b0);
    fork
      host_cmd(2'd2, 8'h80, 1'b0);
      begin @(negedge clk); ext_sda_lo = 1'b1; end
    join
    chk("R11 arb flagged", r_arb, 1);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
    chk("R11 idle", cmd_ready, 1);
    repeat (40) @(negedge clk);
    chk("R11 no stop sent", bus_busy, 1);
    ext_sda_lo = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 bus free after other stop", bus_busy, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_owner();
    t_main();
    t_rate(2'd2, 1'b0, 25, "R2 1MHz period");
    t_rate(2'd1, 1'b0, 62, "R2 400kHz period");
    t_rate(2'd0, 1'b0, 250, "R2 100kHz period");
    t_rate(2'd2, 1'b1, 250, "R3 locked period");
    t_stretch();
    t_busy_refuse();
    t_arb();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule